// File: doc/BRIEF.md
# Programmable Chip-Select Bank Decoder

This block turns a 32-bit system-bus address into one of eight external chip selects. Each bank owns one software-writable configuration word. The word holds a region base aligned to 128 KiB, a per-bit compare-enable field and an enable flag. An address strobe is decoded against all eight words in parallel. One cycle later the block presents either a one-hot chip-select vector or a no-hit flag.

A strap input sampled during reset exchanges chip selects 0 and 1, so that the boot device can sit on either of the two lowest selects. Banks 0 and 1 have a fallback rule. When the whole configuration word of one of them is zero, that bank takes every address that no enabled bank claims, even though its enable flag is clear. To keep such a bank out of the way, software writes all ones to it.

Top module: `csb_decoder`

## Requirements
- R1: While reset is held, the strap `boot_swap_i` is captured. After reset, the word of bank 0 reads 0x00000001 when the strap was low and 0x00000000 when it was high. Banks 1 to 7 read 0x00000000. `cs_o`, `resp_valid_o` and `nohit_o` are 0 during and right after reset.
- R2: The word of bank i is written and read at register offset 0x100 + 0x10*i. `cfg_rdata_o` follows `cfg_addr_i` combinationally. At any other offset a read returns 0 and a write changes no bank word.
- R3: Word bit 0 is the enable. Bits [31:17] are the base. Bits [15:1] are compare enables: bit n set means address bit n+16 must equal word bit n+16. An enabled bank matches when every enabled address bit is equal. Address bits [16:0] and word bit 16 never take part.
- R4: A bank from 2 to 7 with its enable bit clear is never selected.
- R5: When several enabled banks match, the bank with the lowest number is selected.
- R6: If no enabled bank matches, a bank 0 word of 0x00000000 selects bank 0. Failing that, a bank 1 word of 0x00000000 selects bank 1. This fallback ignores the enable bit and has the lowest priority.
- R7: With the strap captured high, the decision for bank 0 drives `cs_o[1]` and the decision for bank 1 drives `cs_o[0]`. The other selects are unchanged. The captured strap value holds until the next reset.
- R8: A decode launched by `req_valid_i` at a rising edge appears at the next edge. `resp_valid_o` is high for that one cycle and `cs_o` is at most one-hot. Without a strobe, `cs_o` is 0 and `nohit_o` is 0.
- R9: When a decode finds neither a matching enabled bank nor a fallback, `nohit_o` is 1 and `cs_o` is 0. Otherwise exactly one bit of `cs_o` is set.
- R10: A configuration write at the same edge as a strobe does not affect that decode. It affects the next decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| boot_swap_i | input | 1 | Boot-swap strap, captured while reset is held |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 12 | Configuration register offset |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data for `cfg_addr_i` |
| req_valid_i | input | 1 | Address strobe |
| req_addr_i | input | 32 | System-bus address to decode |
| cs_o | output | 8 | One-hot chip selects, registered |
| resp_valid_o | output | 1 | Decode result present this cycle |
| nohit_o | output | 1 | Decode found no bank |

## Verification
Addresses are first swept with the reset configuration, where everything lands on the boot select, and then against two nested enabled regions. Offsets in the low 128 KiB and at each edge of a region show that only the masked upper bits are compared. The nesting shows lowest-number priority. A disabled bank whose base matches and addresses outside every region separate "not enabled" from "no region". Clearing bank 1 and then bank 0 completely shows the fallback order. The whole run is repeated with the strap high to expose the 0/1 exchange. Writes at unaligned and out-of-range offsets, and writes that coincide with a strobe, are compared against a cycle-level model on every clock. A closing random phase draws words from a pool that contains all-zero, all-ones and disabled values.

// File: rtl/csb_pkg.sv
package csb_pkg;

   // Register offset of a bank word inside the configuration space.
   function automatic int unsigned bank_offset(input int unsigned base,
                                               input int unsigned stride,
                                               input int unsigned idx);
      return base + idx * stride;
   endfunction

   // Which physical select a logical bank drives when the strap swaps 0 and 1.
   function automatic int unsigned swapped_index(input int unsigned idx,
                                                 input bit swap);
      if (swap && idx == 0) return 1;
      if (swap && idx == 1) return 0;
      return idx;
   endfunction

endpackage

// File: rtl/csb_regfile.sv
module csb_regfile #(
   parameter int unsigned N_BANKS    = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned REG_A_W    = 12,
   parameter int unsigned REG_BASE   = 32'h100,
   parameter int unsigned REG_STRIDE = 32'h10
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        boot_swap,
   input  logic                        we,
   input  logic [REG_A_W-1:0]          addr,
   input  logic [DATA_W-1:0]           wdata,
   output logic [DATA_W-1:0]           rdata,
   output logic [N_BANKS*DATA_W-1:0]   cfg_flat
);
   localparam int unsigned LAST_OFF =
      csb_pkg::bank_offset(REG_BASE, REG_STRIDE, N_BANKS - 1);

   if (LAST_OFF >= (1 << REG_A_W)) begin : g_bad_span
      $error("csb_regfile: bank words do not fit in REG_A_W address bits");
   end
   if (REG_STRIDE == 0) begin : g_bad_stride
      $error("csb_regfile: REG_STRIDE must be nonzero");
   end

   logic [N_BANKS-1:0] sel;

   for (genvar gi = 0; gi < N_BANKS; gi++) begin : g_bank
      localparam logic [REG_A_W-1:0] OFF =
         REG_A_W'(csb_pkg::bank_offset(REG_BASE, REG_STRIDE, gi));
      logic [DATA_W-1:0] word_q;

      assign sel[gi] = (addr == OFF);

      if (gi == 0) begin : g_boot
         // Reset value exposes the strap: enable reads as the inverse of it.
         always_ff @(posedge clk) begin
            if (!rst_n)
               word_q <= {{(DATA_W-1){1'b0}}, ~boot_swap};
            else if (we && sel[gi])
               word_q <= wdata;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)
               word_q <= '0;
            else if (we && sel[gi])
               word_q <= wdata;
         end
      end

      assign cfg_flat[gi*DATA_W +: DATA_W] = word_q;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < N_BANKS; i++) begin
         if (sel[i]) rdata = cfg_flat[i*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/csb_bank_cmp.sv
module csb_bank_cmp #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned GRAN_LSB   = 17,
   parameter int unsigned MASK_SHIFT = 16
) (
   input  logic [ADDR_W-1:0] cfg,
   input  logic [ADDR_W-1:0] addr,
   output logic              match,
   output logic              zero
);
   localparam int unsigned FIELD_W = ADDR_W - GRAN_LSB;
   localparam int unsigned MASK_LO = GRAN_LSB - MASK_SHIFT;
   localparam int unsigned MASK_HI = MASK_LO + FIELD_W - 1;

   if (GRAN_LSB <= MASK_SHIFT) begin : g_bad_gran
      $error("csb_bank_cmp: GRAN_LSB must exceed MASK_SHIFT");
   end
   if (MASK_LO == 0 || MASK_HI >= GRAN_LSB) begin : g_bad_mask
      $error("csb_bank_cmp: compare-enable field overlaps enable or base");
   end

   logic [FIELD_W-1:0] base_f, addr_f, cmp_en, diff;

   assign base_f = cfg[ADDR_W-1:GRAN_LSB];
   assign addr_f = addr[ADDR_W-1:GRAN_LSB];
   assign cmp_en = cfg[MASK_HI:MASK_LO];
   assign diff   = (base_f ^ addr_f) & cmp_en;

   assign match = cfg[0] && (diff == '0);
   assign zero  = (cfg == '0);

endmodule

// File: rtl/csb_prio_sel.sv
module csb_prio_sel #(
   parameter int unsigned N_BANKS = 8,
   parameter int unsigned N_CATCH = 2
) (
   input  logic [N_BANKS-1:0] match,
   input  logic [N_BANKS-1:0] zero,
   input  logic               swap,
   output logic [N_BANKS-1:0] onehot,
   output logic               nohit
);
   if (N_CATCH > N_BANKS || N_BANKS < 2) begin : g_bad_cnt
      $error("csb_prio_sel: need N_BANKS >= 2 and N_CATCH <= N_BANKS");
   end

   logic [N_BANKS-1:0] pick;
   logic               found;

   always_comb begin
      pick  = '0;
      found = 1'b0;
      for (int i = 0; i < N_BANKS; i++) begin
         if (!found && match[i]) begin
            pick[i] = 1'b1;
            found   = 1'b1;
         end
      end
      for (int i = 0; i < N_CATCH; i++) begin
         if (!found && zero[i]) begin
            pick[i] = 1'b1;
            found   = 1'b1;
         end
      end
   end

   assign nohit = !found;

   // Route logical banks to physical selects; only 0 and 1 can trade places.
   for (genvar gi = 0; gi < N_BANKS; gi++) begin : g_route
      localparam int unsigned ALT = csb_pkg::swapped_index(gi, 1'b1);
      if (ALT != gi) begin : g_xchg
         assign onehot[gi] = swap ? pick[ALT] : pick[gi];
      end else begin : g_thru
         assign onehot[gi] = pick[gi];
      end
   end

endmodule

// File: rtl/csb_decoder.sv
module csb_decoder #(
   parameter int unsigned N_BANKS    = 8,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned GRAN_LSB   = 17,
   parameter int unsigned REG_A_W    = 12,
   parameter int unsigned REG_BASE   = 32'h100,
   parameter int unsigned REG_STRIDE = 32'h10,
   parameter int unsigned N_CATCH    = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_n_i,
   input  logic                 boot_swap_i,
   input  logic                 cfg_we_i,
   input  logic [REG_A_W-1:0]   cfg_addr_i,
   input  logic [ADDR_W-1:0]    cfg_wdata_i,
   output logic [ADDR_W-1:0]    cfg_rdata_o,
   input  logic                 req_valid_i,
   input  logic [ADDR_W-1:0]    req_addr_i,
   output logic [N_BANKS-1:0]   cs_o,
   output logic                 resp_valid_o,
   output logic                 nohit_o
);
   localparam int unsigned MASK_SHIFT = ADDR_W / 2;

   if (ADDR_W % 2 != 0) begin : g_bad_aw
      $error("csb_decoder: ADDR_W must be even");
   end

   logic                       swap_q;
   logic [N_BANKS*ADDR_W-1:0]  cfg_flat;
   logic [N_BANKS-1:0]         hit, zero, sel;
   logic                       miss;

   // Strap is sampled for as long as reset is held, then frozen.
   always_ff @(posedge clk_i) begin
      if (!rst_n_i) swap_q <= boot_swap_i;
   end

   csb_regfile #(
      .N_BANKS   (N_BANKS),
      .DATA_W    (ADDR_W),
      .REG_A_W   (REG_A_W),
      .REG_BASE  (REG_BASE),
      .REG_STRIDE(REG_STRIDE)
   ) u_regs (
      .clk      (clk_i),
      .rst_n    (rst_n_i),
      .boot_swap(boot_swap_i),
      .we       (cfg_we_i),
      .addr     (cfg_addr_i),
      .wdata    (cfg_wdata_i),
      .rdata    (cfg_rdata_o),
      .cfg_flat (cfg_flat)
   );

   for (genvar gi = 0; gi < N_BANKS; gi++) begin : g_cmp
      csb_bank_cmp #(
         .ADDR_W    (ADDR_W),
         .GRAN_LSB  (GRAN_LSB),
         .MASK_SHIFT(MASK_SHIFT)
      ) u_cmp (
         .cfg  (cfg_flat[gi*ADDR_W +: ADDR_W]),
         .addr (req_addr_i),
         .match(hit[gi]),
         .zero (zero[gi])
      );
   end

   csb_prio_sel #(
      .N_BANKS(N_BANKS),
      .N_CATCH(N_CATCH)
   ) u_sel (
      .match (hit),
      .zero  (zero),
      .swap  (swap_q),
      .onehot(sel),
      .nohit (miss)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         cs_o         <= '0;
         resp_valid_o <= 1'b0;
         nohit_o      <= 1'b0;
      end else begin
         resp_valid_o <= req_valid_i;
         cs_o         <= req_valid_i ? sel : '0;
         nohit_o      <= req_valid_i && miss;
      end
   end

endmodule

// File: rtl/csb_decoder_chk.sv
module csb_decoder_chk #(
   parameter int unsigned N_BANKS = 8
) (
   input logic               clk_i,
   input logic               rst_n_i,
   input logic               req_valid_i,
   input logic [N_BANKS-1:0] cs_o,
   input logic               resp_valid_o,
   input logic               nohit_o,
   input logic               swap_q
);
   logic armed_q;
   always_ff @(posedge clk_i) armed_q <= rst_n_i;

   assert_cs_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $onehot0(cs_o));

   assert_resp_follows_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      armed_q |-> (resp_valid_o == $past(req_valid_i)));

   assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !resp_valid_o |-> (cs_o == '0 && !nohit_o));

   assert_hit_or_miss_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      resp_valid_o |-> (($countones(cs_o) == 1) != nohit_o));

   assert_strap_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      armed_q |-> $stable(swap_q));

endmodule

bind csb_decoder csb_decoder_chk #(.N_BANKS(N_BANKS)) u_chk (
   .clk_i       (clk_i),
   .rst_n_i     (rst_n_i),
   .req_valid_i (req_valid_i),
   .cs_o        (cs_o),
   .resp_valid_o(resp_valid_o),
   .nohit_o     (nohit_o),
   .swap_q      (swap_q)
);

// File: tb/csb_decoder_tb.sv
module csb_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap = 1'b0;
   logic        cfg_we = 1'b0;
   logic [11:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [7:0]  cs;
   logic        resp_valid, nohit;

   int n_vec = 0;
   int n_fail = 0;
   string tag = "R1";

   always #4 clk = ~clk;

   csb_decoder u_dut (
      .clk_i(clk), .rst_n_i(rst_n), .boot_swap_i(strap),
      .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
      .cfg_rdata_o(cfg_rdata), .req_valid_i(req_valid), .req_addr_i(req_addr),
      .cs_o(cs), .resp_valid_o(resp_valid), .nohit_o(nohit)
   );

   // ---------------- behavioural reference ----------------
   logic [31:0] mw [8];
   bit          mswap;
   logic [7:0]  exp_cs = '0;
   bit          exp_nh = 0, exp_vld = 0, started = 0;

   function automatic int word_index(input logic [11:0] a);
      if (a >= 12'h100 && a < 12'h180 && a[3:0] == 4'h0) return int'((a - 12'h100) >> 4);
      return -1;
   endfunction

   function automatic bit bank_hits(input logic [31:0] w, input logic [31:0] a);
      if (!w[0]) return 0;
      for (int b = 17; b < 32; b++)
         if (w[b-16] && (w[b] != a[b])) return 0;
      return 1;
   endfunction

   always @(posedge clk) begin
      started = 1;
      if (!rst_n) begin
         mswap = strap;
         mw[0] = {31'b0, ~strap};
         for (int i = 1; i < 8; i++) mw[i] = '0;
         exp_cs = '0; exp_nh = 0; exp_vld = 0;
      end else begin
         int win;
         win = -1;
         exp_vld = req_valid;
         exp_cs = '0; exp_nh = 0;
         if (req_valid) begin
            for (int i = 7; i >= 0; i--) if (bank_hits(mw[i], req_addr)) win = i;
            if (win < 0 && mw[0] == 32'h0) win = 0;
            else if (win < 0 && mw[1] == 32'h0) win = 1;
            if (win < 0) exp_nh = 1;
            else begin
               if (mswap && win < 2) win = 1 - win;
               exp_cs[win] = 1'b1;
            end
         end
         if (cfg_we && word_index(cfg_addr) >= 0) mw[word_index(cfg_addr)] = cfg_wdata;
      end
   end

   always @(negedge clk) begin
      if (started) begin
         n_vec++;
         if (cs !== exp_cs || nohit !== exp_nh || resp_valid !== exp_vld) begin
            n_fail++;
            $display("FAIL %s: cs=%b nohit=%b vld=%b expected cs=%b nohit=%b vld=%b addr=%h",
                     tag, cs, nohit, resp_valid, exp_cs, exp_nh, exp_vld, req_addr);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc(input bit we, input logic [11:0] ra, input logic [31:0] wd,
                      input bit v, input logic [31:0] a);
      @(negedge clk);
      #1;
      cfg_we = we; cfg_addr = ra; cfg_wdata = wd; req_valid = v; req_addr = a;
   endtask

   task automatic wr(input logic [11:0] ra, input logic [31:0] wd);
      cyc(1, ra, wd, 0, 32'h0);
   endtask

   task automatic look(input logic [31:0] a);
      cyc(0, 12'h0, 32'h0, 1, a);
   endtask

   task automatic rd_check(input logic [11:0] ra, input logic [31:0] expv, input string t);
      @(negedge clk);
      #1;
      cfg_we = 0; req_valid = 0; cfg_addr = ra;
      #1;
      n_vec++;
      if (cfg_rdata !== expv) begin
         n_fail++;
         $display("FAIL %s: read %h got %h expected %h", t, ra, cfg_rdata, expv);
      end
   endtask

   task automatic do_reset(input bit s);
      @(negedge clk);
      cfg_we = 0; req_valid = 0; strap = s; rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      strap = ~s;   // strap changes after reset must not matter (R7)
   endtask

   task automatic run_suite(input bit s);
      // R1: reset values
      tag = "R1";
      do_reset(s);
      rd_check(12'h100, {31'b0, ~s}, "R1");
      for (int i = 1; i < 8; i++) rd_check(12'(12'h100 + 16*i), 32'h0, "R1");
      // R3/R7: reset configuration sends everything to the boot select
      tag = s ? "R7" : "R3";
      look(32'h0000_0000); look(32'h8000_1234); look(32'hFFFF_FFFF); look(32'h1234_5678);
      cyc(0, 0, 0, 0, 0);
      // park banks 0 and 1, open two nested regions
      wr(12'h100, 32'hFFFF_FFFF);
      wr(12'h110, 32'hFFFF_FFFF);
      wr(12'h120, 32'h1000_FFF1);   // 1 MiB at 0x1000_0000
      wr(12'h130, 32'h1000_FF01);   // 16 MiB at 0x1000_0000
      wr(12'h140, 32'h2000_FFF0);   // disabled, base 0x2000_0000
      tag = "R3";
      look(32'h1000_0000); look(32'h1001_FFFF); look(32'h100F_FFFF); look(32'h10FF_FFFF);
      look(32'h0FFF_FFFF); look(32'h1100_0000); look(32'hFFFE_0000); look(32'hFFFD_FFFF);
      tag = "R5";
      look(32'h1000_0100); look(32'h1080_0000); look(32'h1010_0000);
      tag = "R4";
      look(32'h2000_0000); look(32'h2000_1000);
      tag = "R9";
      look(32'h4000_0000); look(32'h0000_0000);
      // R2: bad offsets ignored, good offsets read back
      tag = "R2";
      wr(12'h104, 32'hDEAD_BEEF); wr(12'h180, 32'hDEAD_BEEF); wr(12'h0F0, 32'hDEAD_BEEF);
      rd_check(12'h104, 32'h0, "R2"); rd_check(12'h180, 32'h0, "R2");
      rd_check(12'h120, 32'h1000_FFF1, "R2"); rd_check(12'h130, 32'h1000_FF01, "R2");
      rd_check(12'h100, 32'hFFFF_FFFF, "R2"); rd_check(12'h140, 32'h2000_FFF0, "R2");
      wr(12'h150, 32'h5000_C001); rd_check(12'h150, 32'h5000_C001, "R2");
      look(32'h5000_0000); look(32'h7000_0000);
      // R6: fallback order
      tag = "R6";
      wr(12'h110, 32'h0);
      look(32'h4000_0000); look(32'h1000_0000);
      wr(12'h100, 32'h0);
      look(32'h4000_0000); look(32'h1000_0000); look(32'h2000_0000);
      wr(12'h100, 32'h0000_0002);   // nonzero but disabled: no fallback for bank 0
      look(32'h4000_0000);
      // R10: write coincident with a strobe
      tag = "R10";
      cyc(1, 12'h170, 32'h4000_FFF1, 1, 32'h4000_0000);
      look(32'h4000_0000);
      cyc(1, 12'h170, 32'h0, 1, 32'h4000_0000);
      look(32'h4000_0000);
      cyc(0, 0, 0, 0, 0);
      // random phase
      tag = "R5";
      for (int k = 0; k < 600; k++) begin
         int pick;
         pick = int'($urandom_range(0, 9));
         if (pick < 3) begin
            logic [31:0] pool [6];
            pool[0] = 32'h0; pool[1] = 32'hFFFF_FFFF; pool[2] = 32'h1000_FFF1;
            pool[3] = 32'h1000_FF00; pool[4] = 32'h0000_8001; pool[5] = {$urandom} | 32'h1;
            cyc(1, 12'(12'h100 + 16 * $urandom_range(0, 7)), pool[$urandom_range(0, 5)],
                $urandom_range(0, 1) == 1, {$urandom_range(0, 15), 28'h0} | ($urandom & 32'h00FF_FFFF));
         end else begin
            cyc(0, 0, 0, $urandom_range(0, 3) != 0,
                {$urandom_range(0, 15), 28'h0} | ($urandom & 32'h01FF_FFFF));
         end
      end
      cyc(0, 0, 0, 0, 0);
   endtask

   initial begin
      run_suite(1'b0);
      run_suite(1'b1);
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule